// File: doc/BRIEF.md
# Multi-Channel Match Timer

The block is a free-running 32-bit up-counter that is shared by four compare channels. Each channel has a 32-bit match value that software can write. On every cycle the counter is compared with every match value. When a channel is enabled and its match value equals the counter, the channel's sticky status bit is set. Each channel drives its own interrupt line, which is high while the channel is both pending and enabled. The counter is intended to run from a 3.6864 MHz timer clock, and that clock is the block's only clock.

Software sees a flat register window. Writes are single-cycle strobes, and reads are combinational. The counter can be reloaded at any time. Status bits are cleared by writing ones to them. A channel can be turned off without losing its pending status.

Top module: `match_timer`

## Requirements
- R1: While reset is asserted, the counter, all four match values, the status bits, the enable bits and all interrupt outputs read zero.
- R2: Without a software write to it, the counter increases by exactly one on every clock edge.
- R3: The counter steps from 0xFFFFFFFF to 0x00000000 and sets no status bit in doing so.
- R4: A write to the counter (address 4) loads the written value at that edge, and counting carries on from that value.
- R5: Register addresses: 0 to 3 are the match values of channels 0 to 3, 4 is the counter, 5 is status (bits 3:0, bit i is channel i), 6 is enable (bits 3:0, bit i is channel i). Each match value and the enable field read back what was last written.
- R6: When channel i is enabled and the counter register equals match value i at a clock edge, status bit i is set at that edge. This happens for all channels together when they share a value.
- R7: A channel whose enable bit is zero never gets its status bit set, even when the counter passes its match value.
- R8: Writing address 5 clears each status bit whose write-data bit is one. Bits written with zero keep their value.
- R9: When a clear and a match of the same status bit fall on the same edge, the bit ends set.
- R10: A counter write whose data equals a match value does not set status at the write edge. The bit is set at the following edge, once the counter register holds the value.
- R11: Interrupt output i equals status bit i ANDed with enable bit i. Turning an enable off drops the interrupt line and leaves the status bit in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Combinational read data for regAddr |
| irqOut | output | 4 | Per-channel interrupt lines |

## Verification
The bench aims at the one-edge lag between the counter register and the status bit. If a design compared against the write data, the bit would be set at the reload edge. If a design compared one count too late, the status bit would not be set at the edge where the bench expects it.

It drives a clear onto the exact edge where a match fires. A design that gives the clear priority would lose the event.

It runs the counter through the all-ones wrap, and it lets a disabled channel pass its match value. A design that mishandles either case would show a stray status bit.

It turns an enable off while the channel is pending. A design that clears status together with the enable, or that leaves the interrupt line ungated, would show it at the ports.

// File: rtl/mt_pkg.sv
package mt_pkg;

  // One-cycle strobes from the register decoder to the datapath.
  typedef struct packed {
    logic cntLoad;    // software reload of the counter
    logic statusClr;  // write-one-to-clear of status
    logic enWr;       // enable field write
  } mtStrobes_t;

endpackage

// File: rtl/mt_ctrl.sv
module mt_ctrl
  import mt_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 3
) (
  input  logic           wrEn,
  input  logic [AW-1:0]  regAddr,
  output mtStrobes_t     stb,
  output logic [NCH-1:0] matchWe
);

  localparam logic [AW-1:0] ADDR_CNT  = AW'(NCH);
  localparam logic [AW-1:0] ADDR_STAT = AW'(NCH + 1);
  localparam logic [AW-1:0] ADDR_EN   = AW'(NCH + 2);

  always_comb begin
    stb.cntLoad   = wrEn && (regAddr == ADDR_CNT);
    stb.statusClr = wrEn && (regAddr == ADDR_STAT);
    stb.enWr      = wrEn && (regAddr == ADDR_EN);
  end

  for (genvar i = 0; i < NCH; i++) begin : g_we
    assign matchWe[i] = wrEn && (regAddr == AW'(i));
  end

endmodule

// File: rtl/mt_datapath.sv
module mt_datapath
  import mt_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 32,
  parameter int AW  = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  mtStrobes_t              stb,
  input  logic [NCH-1:0]          matchWe,
  input  logic [AW-1:0]           regAddr,
  input  logic [CW-1:0]           regWdata,
  output logic [CW-1:0]           regRdata,
  output logic [CW-1:0]           cntVal,
  output logic [NCH-1:0][CW-1:0]  matchVal,
  output logic [NCH-1:0]          statusVal,
  output logic [NCH-1:0]          enVal,
  output logic [NCH-1:0]          irqOut
);

  localparam logic [AW-1:0] ADDR_CNT  = AW'(NCH);
  localparam logic [AW-1:0] ADDR_STAT = AW'(NCH + 1);
  localparam logic [AW-1:0] ADDR_EN   = AW'(NCH + 2);

  logic [CW-1:0]          cntQ;
  logic [NCH-1:0][CW-1:0] matchQ;
  logic [NCH-1:0]         statusQ;
  logic [NCH-1:0]         enQ;
  logic [NCH-1:0]         hit;

  // Shared counter: reload has priority over increment, wraps silently.
  always_ff @(posedge clk) begin
    if (!rstN)            cntQ <= '0;
    else if (stb.cntLoad) cntQ <= regWdata;
    else                  cntQ <= cntQ + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)         enQ <= '0;
    else if (stb.enWr) enQ <= regWdata[NCH-1:0];
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rstN)          matchQ[i] <= '0;
      else if (matchWe[i]) matchQ[i] <= regWdata;
    end

    // Compare against the registered counter, never the write data.
    assign hit[i] = (cntQ == matchQ[i]);

    // Set beats clear on the same edge.
    always_ff @(posedge clk) begin
      if (!rstN)                                statusQ[i] <= 1'b0;
      else if (hit[i] && enQ[i])                statusQ[i] <= 1'b1;
      else if (stb.statusClr && regWdata[i])    statusQ[i] <= 1'b0;
    end

    assign irqOut[i] = statusQ[i] & enQ[i];
  end

  always_comb begin
    regRdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (regAddr == AW'(i)) regRdata = matchQ[i];
    end
    if (regAddr == ADDR_CNT)  regRdata = cntQ;
    if (regAddr == ADDR_STAT) regRdata = CW'(statusQ);
    if (regAddr == ADDR_EN)   regRdata = CW'(enQ);
  end

  assign cntVal    = cntQ;
  assign matchVal  = matchQ;
  assign statusVal = statusQ;
  assign enVal     = enQ;

endmodule

// File: rtl/match_timer.sv
module match_timer
  import mt_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 32,
  parameter int AW  = $clog2(NCH + 3)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           wrEn,
  input  logic [AW-1:0]  regAddr,
  input  logic [CW-1:0]  regWdata,
  output logic [CW-1:0]  regRdata,
  output logic [NCH-1:0] irqOut
);

  mtStrobes_t             stb;
  logic [NCH-1:0]         matchWe;
  logic [CW-1:0]          cntVal;
  logic [NCH-1:0][CW-1:0] matchVal;
  logic [NCH-1:0]         statusVal;
  logic [NCH-1:0]         enVal;

  mt_ctrl #(.NCH(NCH), .AW(AW)) u_ctrl (
    .wrEn    (wrEn),
    .regAddr (regAddr),
    .stb     (stb),
    .matchWe (matchWe)
  );

  mt_datapath #(.NCH(NCH), .CW(CW), .AW(AW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .matchWe   (matchWe),
    .regAddr   (regAddr),
    .regWdata  (regWdata),
    .regRdata  (regRdata),
    .cntVal    (cntVal),
    .matchVal  (matchVal),
    .statusVal (statusVal),
    .enVal     (enVal),
    .irqOut    (irqOut)
  );

endmodule

// File: rtl/mt_checker.sv
module mt_checker #(
  parameter int NCH = 4,
  parameter int CW  = 32,
  parameter int AW  = 3
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   wrEn,
  input logic [AW-1:0]          regAddr,
  input logic [CW-1:0]          regWdata,
  input logic [CW-1:0]          cntVal,
  input logic [NCH-1:0][CW-1:0] matchVal,
  input logic [NCH-1:0]         statusVal,
  input logic [NCH-1:0]         enVal,
  input logic [NCH-1:0]         irqOut
);

  logic           cntWrite;
  logic [NCH-1:0] clrMask;
  logic [NCH-1:0] armed;

  assign cntWrite = wrEn && (regAddr == AW'(NCH));
  assign clrMask  = (wrEn && (regAddr == AW'(NCH + 1))) ? regWdata[NCH-1:0] : '0;

  always_comb begin
    for (int i = 0; i < NCH; i++) armed[i] = enVal[i] && (cntVal == matchVal[i]);
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(cntWrite)) |-> (cntVal == $past(cntVal) + CW'(1)));

  // R4
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(cntWrite)) |-> (cntVal == $past(regWdata)));

  // R6
  match_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ((statusVal & $past(armed)) == $past(armed)));

  // R7
  no_stray_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ((statusVal & ~$past(statusVal) & ~$past(armed)) == '0));

  // R8
  clear_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ((~statusVal & $past(statusVal) & ~$past(clrMask)) == '0));

  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((irqOut & ~(statusVal & enVal)) == '0) && (((statusVal & enVal) & ~irqOut) == '0));

endmodule

bind match_timer mt_checker #(.NCH(NCH), .CW(CW), .AW(AW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .regAddr   (regAddr),
  .regWdata  (regWdata),
  .cntVal    (cntVal),
  .matchVal  (matchVal),
  .statusVal (statusVal),
  .enVal     (enVal),
  .irqOut    (irqOut)
);

// File: tb/match_timer_bench.sv
`timescale 1ns/1ps
module match_timer_bench;

  localparam int A_CNT = 4;
  localparam int A_STA = 5;
  localparam int A_EN  = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [3:0]  irqOut;

  int nChecks = 0;
  int nFail   = 0;

  always #10 clk = ~clk;

  match_timer u_match_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeReg(input int addr, input logic [31:0] data);
    wrEn = 1'b1; regAddr = 3'(addr); regWdata = data;
    @(negedge clk);
    wrEn = 1'b0; regWdata = '0;
  endtask

  task automatic readReg(input int addr, output logic [31:0] val);
    regAddr = 3'(addr);
    #1;
    val = regRdata;
  endtask

  task automatic test_reset;
    logic [31:0] v;
    for (int a = 0; a < 7; a++) begin
      readReg(a, v);
      check($sformatf("R1 reset addr %0d", a), v, 32'h0);
    end
    check("R1 reset irq", {28'h0, irqOut}, 32'h0);
  endtask

  task automatic test_count;
    logic [31:0] a, b;
    readReg(A_CNT, a);
    tick(1);
    readReg(A_CNT, b);
    check("R2 step of one", b, a + 32'd1);
    tick(5);
    readReg(A_CNT, b);
    check("R2 six steps", b, a + 32'd6);
  endtask

  task automatic test_wrap;
    logic [31:0] v;
    writeReg(A_CNT, 32'hFFFF_FFFF);
    readReg(A_CNT, v);
    check("R4 counter load", v, 32'hFFFF_FFFF);
    tick(1);
    readReg(A_CNT, v);
    check("R3 wrap to zero", v, 32'h0);
    readReg(A_STA, v);
    check("R3 no flag on wrap", v, 32'h0);
  endtask

  task automatic test_regs;
    logic [31:0] v;
    for (int i = 0; i < 4; i++) writeReg(i, 32'h1000_0000 * (i + 1) + 32'(i));
    for (int i = 0; i < 4; i++) begin
      readReg(i, v);
      check($sformatf("R5 match %0d readback", i), v, 32'h1000_0000 * (i + 1) + 32'(i));
    end
    writeReg(A_EN, 32'hA);
    readReg(A_EN, v);
    check("R5 enable readback", v, 32'hA);
    writeReg(A_EN, 32'h0);
  endtask

  task automatic test_match;
    logic [31:0] v;
    writeReg(0, 32'd1000);
    writeReg(A_EN, 32'h1);
    writeReg(A_CNT, 32'd997);
    tick(3);
    readReg(A_STA, v);
    check("R6 not before equality", v, 32'h0);
    tick(1);
    readReg(A_STA, v);
    check("R6 set on equality", v, 32'h1);
    check("R11 irq follows status", {28'h0, irqOut}, 32'h1);
  endtask

  task automatic test_disabled;
    logic [31:0] v;
    writeReg(1, 32'd2000);
    writeReg(A_CNT, 32'd1999);
    tick(3);
    readReg(A_STA, v);
    check("R7 disabled channel stays clear", v, 32'h1);
    check("R7 disabled channel no irq", {28'h0, irqOut}, 32'h1);
  endtask

  task automatic test_clear;
    logic [31:0] v;
    writeReg(A_STA, 32'h0);
    readReg(A_STA, v);
    check("R8 zero write keeps bit", v, 32'h1);
    writeReg(A_STA, 32'h1);
    readReg(A_STA, v);
    check("R8 one write clears bit", v, 32'h0);
    check("R8 irq drops after clear", {28'h0, irqOut}, 32'h0);
  endtask

  task automatic test_race;
    logic [31:0] v;
    writeReg(A_CNT, 32'd1000);
    writeReg(A_STA, 32'h1);   // clear lands on the matching edge
    readReg(A_STA, v);
    check("R9 match wins over clear", v, 32'h1);
  endtask

  task automatic test_writehit;
    logic [31:0] v;
    writeReg(2, 32'd3000);
    writeReg(A_EN, 32'h5);
    writeReg(A_STA, 32'hF);
    writeReg(A_CNT, 32'd3000);
    readReg(A_STA, v);
    check("R10 no set at write edge", v, 32'h0);
    tick(1);
    readReg(A_STA, v);
    check("R10 set one edge later", v, 32'h4);
    check("R10 irq channel 2", {28'h0, irqOut}, 32'h4);
  endtask

  task automatic test_allch;
    logic [31:0] v;
    for (int i = 0; i < 4; i++) writeReg(i, 32'd5000);
    writeReg(A_EN, 32'hF);
    writeReg(A_STA, 32'hF);
    writeReg(A_CNT, 32'd5000);
    tick(1);
    readReg(A_STA, v);
    check("R6 all channels together", v, 32'hF);
    check("R11 all irq lines", {28'h0, irqOut}, 32'hF);
  endtask

  task automatic test_gate;
    logic [31:0] v;
    writeReg(A_EN, 32'h0);
    readReg(A_STA, v);
    check("R11 status kept when disabled", v, 32'hF);
    check("R11 irq gated by enable", {28'h0, irqOut}, 32'h0);
  endtask

  initial begin
    #(20 * 100000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    tick(3);
    test_reset;
    rstN = 1'b1;
    test_count;
    test_wrap;
    test_regs;
    test_match;
    test_disabled;
    test_clear;
    test_race;
    test_writehit;
    test_allch;
    test_gate;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule